// File: doc/BRIEF.md
# Sync Clock Phase Aligner

This block produces a slow alignment clock for multi-synthesizer systems by dividing the system clock by a power of two (by four with default parameters). Several devices that share a reference can line up their internal update timing by shifting the phase of this divided clock. The phase moves forward in whole system-clock periods. A shift happens in three ways. A software command bit moves it one period and then clears itself. A hardware mode moves it one period for every rising edge on the external `sync_in` pin. A one-shot automatic alignment snaps the divided clock onto the first `sync_in` edge it sees.

The alignment input is asynchronous. It passes through a multi-flop synchronizer and a rising-edge detector before any logic uses it. While the hardware mode or the automatic alignment is enabled, the shared lock/sync pin must act as an input, and the block reports this on a direction output. A disable bit forces the clock output low. The phase counter keeps running behind it, so turning the output back on restores the same phase.

Top module: `sync_phase_aligner`

## Requirements
- R1: Out of reset with no phase commands, `sync_clk` is a free-running clock with a period of 4 system clocks, high for 2 and low for 2.
- R2: A one-cycle pulse on `sw_step_cmd` makes `sw_step_pend` read 1 for exactly the next cycle, after which it clears by itself.
- R3: Each software command advances the `sync_clk` rising edges by one system-clock period, so N commands move the phase earlier by N cycles modulo 4.
- R4: While `hw_step_en` is 1, each rising edge on `sync_in` advances `sync_clk` by one system-clock period. The mode bit is a level and is never cleared by the block.
- R5: While `hw_step_en` and `auto_align_en` are both 0, edges on `sync_in` do not change the phase of `sync_clk`.
- R6: Once `auto_align_en` has been 1 for at least one cycle, the first `sync_in` rising edge is taken. If `sync_in` is first high at the clock edge after cycle c, `sync_clk` rises at clock edge c+3 and every 4 cycles after that.
- R7: Automatic alignment acts once. Later `sync_in` edges do not realign while `auto_align_en` stays 1. Dropping and then raising `auto_align_en` re-arms it.
- R8: `sync_pin_input` reads 1, one cycle after `hw_step_en` or `auto_align_en` is 1, and reads 0, one cycle after both are 0.
- R9: While `sclk_off` is 1, `sync_clk` stays 0 from the next cycle on. The phase counter keeps running, so the phase after the output is re-enabled equals the phase before it was disabled.
- R10: During reset, `sync_clk`, `sw_step_pend` and `sync_pin_input` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_step_cmd | input | 1 | Write strobe of the self-clearing software step bit |
| hw_step_en | input | 1 | Hardware step mode: one step per `sync_in` rising edge |
| auto_align_en | input | 1 | One-shot automatic alignment enable |
| sclk_off | input | 1 | Forces `sync_clk` low |
| sync_in | input | 1 | Asynchronous external alignment input |
| sync_clk | output | 1 | Divided, phase-adjustable sync clock (registered) |
| sw_step_pend | output | 1 | Readback of the software step bit (self-clearing) |
| sync_pin_input | output | 1 | 1 while the shared lock/sync pin must be an input |

## Verification
The counter-step assertions assume at most one source of phase change acts in a given cycle. The bench therefore never sends a software command in the same cycle that a hardware edge or an alignment reaches the counter: commands, edges and alignments are separated by idle gaps longer than the synchronizer latency. The `sync_in` stimulus is driven on falling clock edges and held high and low for three cycles each, so every pulse gives exactly one detected rising edge. The control levels are changed only while `sync_in` is quiet and the synchronizer has drained.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    AL_IDLE  = 2'd0,
    AL_ARMED = 2'd1,
    AL_DONE  = 2'd2
  } align_st_e;

endpackage

// File: rtl/spa_edge_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
module spa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sh_q[LAST];
  end

  assign rise_o = sh_q[LAST] & ~last_q;

endmodule

// File: rtl/spa_align_fsm.sv
// One-shot alignment controller: arms while enabled, fires on the first edge,
// then waits for the enable to drop before it can arm again.
module spa_align_fsm
  import spa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic edge_i,
  output logic force_o
);

  align_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      AL_IDLE:  if (en_i) st_d = AL_ARMED;
      AL_ARMED: begin
        if (!en_i)       st_d = AL_IDLE;
        else if (edge_i) st_d = AL_DONE;
      end
      AL_DONE:  if (!en_i) st_d = AL_IDLE;
      default:  st_d = AL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= AL_IDLE;
    else     st_q <= st_d;
  end

  assign force_o = (st_q == AL_ARMED) && en_i && edge_i;

endmodule

// File: rtl/spa_phase_ctr.sv
// Divider counter. A step adds one extra count (skips a state), which moves
// the divided clock one system-clock period earlier. Force loads the phase
// at which the divided clock's high half begins.
module spa_phase_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_step_i,
  input  logic             hw_step_i,
  input  logic             force_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);

  localparam logic [CNT_W-1:0] ALIGN_PH = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (force_i) cnt_d = ALIGN_PH;
    else         cnt_d = cnt_q + ONE + CNT_W'(sw_step_i) + CNT_W'(hw_step_i);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

endmodule

// File: rtl/sync_phase_aligner.sv
module sync_phase_aligner #(
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_step_cmd,
  input  logic hw_step_en,
  input  logic auto_align_en,
  input  logic sclk_off,
  input  logic sync_in,
  output logic sync_clk,
  output logic sw_step_pend,
  output logic sync_pin_input
);

  localparam int MSB = CNT_W - 1;

  logic             sw_pend_q;
  logic             edge_rise;
  logic             hw_step;
  logic             force_al;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             sclk_q;
  logic             pin_in_q;

  // Self-clearing software step bit: holds for one cycle per write.
  always_ff @(posedge clk) begin
    if (rst) sw_pend_q <= 1'b0;
    else     sw_pend_q <= sw_step_cmd;
  end

  spa_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (sync_in),
    .rise_o  (edge_rise)
  );

  assign hw_step = hw_step_en & edge_rise;

  spa_align_fsm u_align (
    .clk     (clk),
    .rst     (rst),
    .en_i    (auto_align_en),
    .edge_i  (edge_rise),
    .force_o (force_al)
  );

  spa_phase_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .sw_step_i  (sw_pend_q),
    .hw_step_i  (hw_step),
    .force_i    (force_al),
    .cnt_o      (cnt_q),
    .cnt_next_o (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      pin_in_q <= 1'b0;
    end else begin
      sclk_q   <= cnt_d[MSB] & ~sclk_off;
      pin_in_q <= hw_step_en | auto_align_en;
    end
  end

  assign sync_clk       = sclk_q;
  assign sw_step_pend   = sw_pend_q;
  assign sync_pin_input = pin_in_q;

endmodule

// File: rtl/spa_sva.sv
module spa_sva #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_step_cmd,
  input logic             hw_step_en,
  input logic             auto_align_en,
  input logic             sclk_off,
  input logic             sync_clk,
  input logic             sw_step_pend,
  input logic             sync_pin_input,
  input logic [CNT_W-1:0] cnt,
  input logic             hw_step,
  input logic             force_al
);

  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TWO      = ONE + ONE;
  localparam logic [CNT_W-1:0] ALIGN_PH = {1'b1, {(CNT_W-1){1'b0}}};

  logic aligned_q;

  always_ff @(posedge clk) begin
    if (rst || !auto_align_en) aligned_q <= 1'b0;
    else if (force_al)         aligned_q <= 1'b1;
  end

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    (!sw_step_pend && !hw_step && !force_al) |=> (cnt == $past(cnt) + ONE)); // R1

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    sw_step_cmd |=> sw_step_pend); // R2

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !sw_step_cmd |=> !sw_step_pend); // R2

  AST_SW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (sw_step_pend && !hw_step && !force_al) |=> (cnt == $past(cnt) + TWO)); // R3

  AST_HW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (hw_step && !sw_step_pend && !force_al) |=> (cnt == $past(cnt) + TWO)); // R4

  AST_ALIGN_PHASE: assert property (@(posedge clk) disable iff (rst)
    force_al |=> (cnt == ALIGN_PH)); // R6

  AST_ALIGN_ONCE: assert property (@(posedge clk) disable iff (rst)
    aligned_q |-> !force_al); // R7

  AST_PIN_INPUT: assert property (@(posedge clk) disable iff (rst)
    (hw_step_en || auto_align_en) |=> sync_pin_input); // R8

  AST_PIN_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (!hw_step_en && !auto_align_en) |=> !sync_pin_input); // R8

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    sclk_off |=> !sync_clk); // R9

endmodule

bind sync_phase_aligner spa_sva #(
  .CNT_W (CNT_W)
) u_sva (
  .clk            (clk),
  .rst            (rst),
  .sw_step_cmd    (sw_step_cmd),
  .hw_step_en     (hw_step_en),
  .auto_align_en  (auto_align_en),
  .sclk_off       (sclk_off),
  .sync_clk       (sync_clk),
  .sw_step_pend   (sw_step_pend),
  .sync_pin_input (sync_pin_input),
  .cnt            (cnt_q),
  .hw_step        (hw_step),
  .force_al       (force_al)
);

// File: tb/sync_phase_aligner_tb.sv
`timescale 1ns/1ps
module sync_phase_aligner_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_step_cmd = 1'b0;
  logic hw_step_en = 1'b0;
  logic auto_align_en = 1'b0;
  logic sclk_off = 1'b0;
  logic sync_in = 1'b0;
  logic sync_clk, sw_step_pend, sync_pin_input;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_phase_aligner u_dut (
    .clk            (clk),
    .rst            (rst),
    .sw_step_cmd    (sw_step_cmd),
    .hw_step_en     (hw_step_en),
    .auto_align_en  (auto_align_en),
    .sclk_off       (sclk_off),
    .sync_in        (sync_in),
    .sync_clk       (sync_clk),
    .sw_step_pend   (sw_step_pend),
    .sync_pin_input (sync_pin_input)
  );

  // Rows: software commands, sync_in pulses, hardware mode, expected advance.
  localparam int NV = 8;
  localparam int VEC [0:NV-1][0:3] = '{
    '{1, 0, 0, 1},
    '{2, 0, 0, 2},
    '{0, 1, 1, 1},
    '{0, 3, 1, 3},
    '{0, 2, 0, 0},
    '{1, 1, 1, 2},
    '{3, 0, 0, 3},
    '{0, 0, 1, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Rising-edge position of sync_clk, as (cycle index mod 4); -1 if none.
  task automatic measure(output int ph);
    logic prev;
    ph = -1;
    repeat (6) @(negedge clk);
    prev = sync_clk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sync_clk && !prev && ph < 0) ph = cyc % 4;
      prev = sync_clk;
    end
  endtask

  task automatic sw_cmd();
    @(negedge clk) sw_step_cmd = 1'b1;
    @(negedge clk) sw_step_cmd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_in(output int c);
    @(negedge clk);
    sync_in = 1'b1;
    c = cyc;
    repeat (3) @(negedge clk);
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    int ph0, ph1, ph2, c, r1, f1, r2, ones;
    logic prev;

    // R10: reset values
    repeat (3) @(negedge clk);
    chk("R10 sync_clk", sync_clk, 0);
    chk("R10 pend", sw_step_pend, 0);
    chk("R10 pin", sync_pin_input, 0);
    @(negedge clk) rst = 1'b0;

    // R1: period and duty
    r1 = -1; f1 = -1; r2 = -1;
    prev = sync_clk;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sync_clk && !prev) begin
        if (r1 < 0) r1 = cyc;
        else if (r2 < 0) r2 = cyc;
      end
      if (!sync_clk && prev && r1 >= 0 && f1 < 0) f1 = cyc;
      prev = sync_clk;
    end
    chk("R1 period", r2 - r1, 4);
    chk("R1 high time", f1 - r1, 2);

    // R2: self-clearing software bit
    @(negedge clk) sw_step_cmd = 1'b1;
    @(negedge clk) sw_step_cmd = 1'b0;
    chk("R2 pend set", sw_step_pend, 1);
    @(negedge clk);
    chk("R2 pend cleared", sw_step_pend, 0);

    // Vector table: R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      string req;
      int c_unused;
      measure(ph0);
      if (VEC[v][2] != 0) @(negedge clk) hw_step_en = 1'b1;
      for (int k = 0; k < VEC[v][0]; k++) sw_cmd();
      for (int k = 0; k < VEC[v][1]; k++) pulse_in(c_unused);
      if (VEC[v][2] != 0) begin
        repeat (4) @(negedge clk);
        chk("R4 mode bit level", hw_step_en, 1);
        hw_step_en = 1'b0;
      end
      measure(ph1);
      if (VEC[v][1] > 0 && VEC[v][2] != 0) req = "R4 hw advance";
      else if (VEC[v][1] > 0)              req = "R5 edges ignored";
      else                                 req = "R3 sw advance";
      chk(req, (ph0 - ph1 + 4) % 4, VEC[v][3]);
    end

    // R6 / R8: automatic alignment
    @(negedge clk) auto_align_en = 1'b1;
    @(negedge clk);
    chk("R8 pin input (auto)", sync_pin_input, 1);
    repeat (2) @(negedge clk);
    pulse_in(c);
    measure(ph0);
    chk("R6 aligned phase", ph0, (c + 3) % 4);

    // R7: one-shot, later edge ignored
    sw_cmd();
    measure(ph1);
    chk("R7 step after align", ph1, (ph0 + 3) % 4);
    pulse_in(c);
    measure(ph2);
    chk("R7 no realign", ph2, ph1);

    // R7: re-arm
    @(negedge clk) auto_align_en = 1'b0;
    repeat (2) @(negedge clk);
    auto_align_en = 1'b1;
    repeat (3) @(negedge clk);
    pulse_in(c);
    measure(ph0);
    chk("R7 re-armed align", ph0, (c + 3) % 4);
    @(negedge clk) auto_align_en = 1'b0;
    @(negedge clk);
    chk("R8 pin output", sync_pin_input, 0);
    hw_step_en = 1'b1;
    @(negedge clk);
    chk("R8 pin input (hw)", sync_pin_input, 1);
    hw_step_en = 1'b0;
    @(negedge clk);
    chk("R8 pin output again", sync_pin_input, 0);

    // R9: disable holds output low, phase preserved
    measure(ph0);
    @(negedge clk) sclk_off = 1'b1;
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (sync_clk) ones++;
    end
    chk("R9 output low", ones, 0);
    sclk_off = 1'b0;
    measure(ph1);
    chk("R9 phase kept", ph1, ph0);

    // R10: reset in mid-run
    @(negedge clk) begin
      rst = 1'b1;
      sw_step_cmd = 1'b1;
      hw_step_en = 1'b1;
    end
    @(negedge clk);
    chk("R10 mid sync_clk", sync_clk, 0);
    chk("R10 mid pend", sw_step_pend, 0);
    chk("R10 mid pin", sync_pin_input, 0);
    sw_step_cmd = 1'b0;
    hw_step_en = 1'b0;
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);

    report();
  end

endmodule